// File: doc/BRIEF.md
# EDO DRAM Strobe Cycle Decoder

This block is the control decoder found on the device side of an extended-data-out DRAM, written as synthesizable logic so a bench can use it as a memory model. It watches the row strobe, column strobe, write enable and output enable. All four are active low. They are sampled on a fast clock that runs many times faster than the strobes change. The block names each cycle from the order in which those edges arrive. It latches row and column addresses, keeps a refresh row counter, and controls when read data is driven.

The storage behind it is a small array with one cell per row/column pair. Read data is registered as it leaves the array. Once driven, the data stays valid after the column strobe rises, until a release condition occurs. Every output is registered. An edge sampled at a clock edge affects the outputs one clock later.

Cycle kind codes on `cyc_kind`:

| Code | Cycle |
|------|-------|
| 0 | standby |
| 1 | read |
| 2 | early write |
| 3 | read-modify-write |
| 4 | page read |
| 5 | page write |
| 6 | row-only refresh |
| 7 | counter refresh |
| 8 | hidden refresh |
| 9 | test-mode entry |

Top module: `edo_strobe_decoder`

## Requirements
- R1: After synchronous reset, `dout_en`=0, `cyc_kind`=0, `seq_err`=0, `test_mode`=0 and `rfsh_row`=0, and the refresh counter restarts at row 0.
- R2: A row-strobe fall with the column strobe high latches `addr` as the row. A later column-strobe fall with `we_n` high reads the cell at that row and column. One clock after that edge is sampled, `dout_en`=1, `dout` shows the stored byte and `cyc_kind`=1.
- R3: A column-strobe fall with `we_n` already low writes `din` to the addressed cell and sets `cyc_kind`=2. `dout_en` stays 0 through the whole cycle.
- R4: If `we_n` falls while the column strobe is low after a read in that strobe, `din` is written to the same cell and `cyc_kind`=3. The read byte stays on `dout`.
- R5: A second or later column access within one row-strobe low period reports `cyc_kind`=4 for a read and `cyc_kind`=5 for a write.
- R6: Driven read data stays valid when only the column strobe rises. `dout_en` drops when `oe_n` is high, when `we_n` falls with the column strobe high during a page read, or when both strobes are high. `oe_n` returning low drives the held byte again.
- R7: A row-strobe low pulse with the column strobe high throughout, and no column access, sets `cyc_kind`=6 and `rfsh_row` to the latched row. `dout_en` stays 0.
- R8: A row-strobe fall while the column strobe is already low and `we_n` is high is a counter refresh. It sets `cyc_kind`=7 and `rfsh_row` to the counter value, and ignores `addr`. The counter then advances by one and wraps from 2^ADDR_W-1 to 0.
- R9: A counter refresh that starts while read data is held is a hidden refresh. It sets `cyc_kind`=8 and read data stays on `dout`.
- R10: A counter refresh with `we_n` low at the row-strobe fall sets `cyc_kind`=9 and `test_mode`=1, and does not advance the counter. The next row-only or counter refresh clears `test_mode`.
- R11: Both strobes falling in the same sample, or a column-strobe fall inside a refresh cycle, gives a one-clock `seq_err` pulse. In that case the array and `cyc_kind` are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_en | output | 1 | Read data is being driven |
| cyc_kind | output | 4 | Code of the last classified cycle |
| rfsh_row | output | ADDR_W | Row refreshed by the last refresh cycle |
| test_mode | output | 1 | Test mode has been entered |
| seq_err | output | 1 | One-clock pulse on an undefined strobe order |

## Verification
A wrong phase or a stale access flag shows up as the wrong `cyc_kind` one clock after the offending edge. Examples are a page access reported as a first access, or a refresh reported as a row-only cycle. A hold flag that is set or cleared at the wrong time changes `dout_en` in that same cycle. A bad write address or a write that should have been suppressed stays hidden until the cell is read back. For that reason every write, and every error case, is followed by a read of the affected cell. A counter that is off by one shows on `rfsh_row` at the next counter refresh, and the wrap test walks past the last row.

// File: rtl/edo_dec_pkg.sv
package edo_dec_pkg;
  typedef enum logic [3:0] {
    KIND_STANDBY  = 4'd0,
    KIND_READ     = 4'd1,
    KIND_EARLY_WR = 4'd2,
    KIND_RMW      = 4'd3,
    KIND_PAGE_RD  = 4'd4,
    KIND_PAGE_WR  = 4'd5,
    KIND_RAS_ONLY = 4'd6,
    KIND_CBR      = 4'd7,
    KIND_HIDDEN   = 4'd8,
    KIND_TEST     = 4'd9
  } cyc_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ROW  = 2'd1,
    PH_RFSH = 2'd2
  } phase_e;

  localparam int N_STROBE = 3;
  localparam int S_RAS    = 0;
  localparam int S_CAS    = 1;
  localparam int S_WE     = 2;
endpackage

// File: rtl/edo_strobe_edges.sv
module edo_strobe_edges #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_n,
  output logic [N-1:0] fall,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_edge
    logic prev_q;
    always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b1;
      else     prev_q <= lvl_n[i];
    end
    assign fall[i] = prev_q & ~lvl_n[i];
    assign rise[i] = ~prev_q & lvl_n[i];
  end
endmodule

// File: rtl/edo_cell_array.sv
module edo_cell_array #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/edo_cycle_ctrl.sv
module edo_cycle_ctrl
  import edo_dec_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2 * ADDR_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic                oe_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   din,
  input  logic [N_STROBE-1:0] fall,
  input  logic [N_STROBE-1:0] rise,
  output logic                mem_we,
  output logic [IDX_W-1:0]    mem_waddr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                mem_re,
  output logic [IDX_W-1:0]    mem_raddr,
  output logic                dout_en,
  output cyc_kind_e           kind,
  output logic [ADDR_W-1:0]   rfsh_row,
  output logic                test_mode,
  output logic                seq_err
);
  localparam int ROWS = 1 << ADDR_W;

  function automatic logic [ADDR_W-1:0] next_row(input logic [ADDR_W-1:0] r);
    return (r == ADDR_W'(ROWS - 1)) ? '0 : r + 1'b1;
  endfunction

  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
  logic unused_we_rise;
  assign ras_fall       = fall[S_RAS];
  assign ras_rise       = rise[S_RAS];
  assign cas_fall       = fall[S_CAS];
  assign cas_rise       = rise[S_CAS];
  assign we_fall        = fall[S_WE];
  assign unused_we_rise = rise[S_WE];

  phase_e            phase_q, phase_d;
  logic [ADDR_W-1:0] row_q, row_d, col_q, col_d, cnt_q, cnt_d, rfsh_q, rfsh_d;
  logic              acc_q, acc_d, rdc_q, rdc_d, hold_q, hold_d;
  logic              test_q, test_d, err_q, err_d, den_q;
  cyc_kind_e         kind_q, kind_d;

  always_comb begin
    phase_d   = phase_q;
    row_d     = row_q;
    col_d     = col_q;
    acc_d     = acc_q;
    rdc_d     = rdc_q;
    hold_d    = hold_q;
    cnt_d     = cnt_q;
    rfsh_d    = rfsh_q;
    kind_d    = kind_q;
    test_d    = test_q;
    err_d     = 1'b0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_waddr = {row_q, addr};
    mem_raddr = {row_q, addr};
    mem_wdata = din;
    if (ras_fall && cas_fall) begin
      err_d = 1'b1;
    end else if (ras_fall) begin
      if (cas_n) begin
        phase_d = PH_ROW;
        row_d   = addr;
        acc_d   = 1'b0;
      end else if (!we_n) begin
        phase_d = PH_RFSH;
        kind_d  = KIND_TEST;
        test_d  = 1'b1;
      end else begin
        phase_d = PH_RFSH;
        kind_d  = hold_q ? KIND_HIDDEN : KIND_CBR;
        rfsh_d  = cnt_q;
        cnt_d   = next_row(cnt_q);
        test_d  = 1'b0;
      end
    end else if (ras_rise) begin
      if (phase_q == PH_ROW && !acc_q) begin
        kind_d = KIND_RAS_ONLY;
        rfsh_d = row_q;
        test_d = 1'b0;
      end
      phase_d = PH_IDLE;
    end else if (cas_fall && !ras_n) begin
      if (phase_q == PH_ROW) begin
        col_d = addr;
        acc_d = 1'b1;
        if (!we_n) begin
          mem_we = 1'b1;
          kind_d = acc_q ? KIND_PAGE_WR : KIND_EARLY_WR;
          hold_d = 1'b0;
          rdc_d  = 1'b0;
        end else begin
          mem_re = 1'b1;
          kind_d = acc_q ? KIND_PAGE_RD : KIND_READ;
          hold_d = 1'b1;
          rdc_d  = 1'b1;
        end
      end else begin
        err_d = 1'b1;
      end
    end else if (we_fall && !ras_n && phase_q == PH_ROW) begin
      if (!cas_n && rdc_q) begin
        mem_we    = 1'b1;
        mem_waddr = {row_q, col_q};
        kind_d    = KIND_RMW;
        rdc_d     = 1'b0;
      end else if (cas_n) begin
        hold_d = 1'b0;
      end
    end
    if (cas_rise) rdc_d = 1'b0;
    if (ras_n && cas_n) hold_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      acc_q   <= 1'b0;
      rdc_q   <= 1'b0;
      hold_q  <= 1'b0;
      cnt_q   <= '0;
      rfsh_q  <= '0;
      kind_q  <= KIND_STANDBY;
      test_q  <= 1'b0;
      err_q   <= 1'b0;
      den_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      row_q   <= row_d;
      col_q   <= col_d;
      acc_q   <= acc_d;
      rdc_q   <= rdc_d;
      hold_q  <= hold_d;
      cnt_q   <= cnt_d;
      rfsh_q  <= rfsh_d;
      kind_q  <= kind_d;
      test_q  <= test_d;
      err_q   <= err_d;
      den_q   <= hold_d & ~oe_n;
    end
  end

  assign dout_en   = den_q;
  assign kind      = kind_q;
  assign rfsh_row  = rfsh_q;
  assign test_mode = test_q;
  assign seq_err   = err_q;

  // R6
  oe_release_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> !dout_en);

  // R6
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    (ras_n && cas_n) |=> !dout_en);

  // R3
  early_wr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cas_fall && !ras_fall && !ras_n && phase_q == PH_ROW && !we_n) |=> !dout_en);

  // R8
  cbr_count_chk: assert property (@(posedge clk) disable iff (rst)
    (ras_fall && !cas_fall && !cas_n && we_n) |=> (cnt_q == next_row($past(cnt_q))));

  // R10
  test_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (ras_fall && !cas_fall && !cas_n && !we_n) |=> (test_mode && kind == KIND_TEST));
endmodule

// File: rtl/edo_strobe_decoder.sv
module edo_strobe_decoder
  import edo_dec_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic [3:0]        cyc_kind,
  output logic [ADDR_W-1:0] rfsh_row,
  output logic              test_mode,
  output logic              seq_err
);
  localparam int IDX_W = 2 * ADDR_W;

  logic [N_STROBE-1:0] fall, rise;
  logic                mem_we, mem_re;
  logic [IDX_W-1:0]    mem_waddr, mem_raddr;
  logic [DATA_W-1:0]   mem_wdata, rdata;
  cyc_kind_e           kind;

  edo_strobe_edges #(.N(N_STROBE)) u_edges (
    .clk   (clk),
    .rst   (rst),
    .lvl_n ({we_n, cas_n, ras_n}),
    .fall  (fall),
    .rise  (rise)
  );

  edo_cycle_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .addr      (addr),
    .din       (din),
    .fall      (fall),
    .rise      (rise),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .mem_re    (mem_re),
    .mem_raddr (mem_raddr),
    .dout_en   (dout_en),
    .kind      (kind),
    .rfsh_row  (rfsh_row),
    .test_mode (test_mode),
    .seq_err   (seq_err)
  );

  edo_cell_array #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_cells (
    .clk   (clk),
    .rst   (rst),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .re    (mem_re),
    .raddr (mem_raddr),
    .rdata (rdata)
  );

  assign cyc_kind = kind;
  assign dout     = dout_en ? rdata : '0;

  // R11
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    seq_err |-> $stable(cyc_kind));
endmodule

// File: tb/edo_strobe_decoder_tb.sv
module edo_strobe_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 51;

  typedef struct packed {
    logic       ras, cas, we, oe;
    logic [2:0] addr;
    logic [7:0] din;
    logic       en;
    logic [7:0] dout;
    logic [3:0] kind;
    logic       err;
    logic [3:0] req;
  } vec_t;

  function automatic vec_t mk(bit r, bit c, bit w, bit o, int a, int d,
                              bit en, int q, int k, bit e, int rq);
    vec_t v;
    v.ras = r; v.cas = c; v.we = w; v.oe = o;
    v.addr = 3'(a); v.din = 8'(d); v.en = en; v.dout = 8'(q);
    v.kind = 4'(k); v.err = e; v.req = 4'(rq);
    return v;
  endfunction

  // fields: ras cas we oe addr din | en dout kind err req
  localparam vec_t VEC [NV] = '{
    mk(1,1,1,0,0,'h00, 0,'h00,0,0, 1),   // R1 idle
    mk(0,1,1,0,2,'h00, 0,'h00,0,0, 2),   // R2 open row 2
    mk(0,0,0,0,5,'hA5, 0,'h00,2,0, 3),   // R3 early write
    mk(0,1,1,0,5,'h00, 0,'h00,2,0, 3),   // R3
    mk(0,0,0,0,6,'h3C, 0,'h00,5,0, 5),   // R5 page write
    mk(0,1,1,0,6,'h00, 0,'h00,5,0, 5),
    mk(1,1,1,0,0,'h00, 0,'h00,5,0, 5),
    mk(0,1,1,0,2,'h00, 0,'h00,5,0, 2),
    mk(0,0,1,0,5,'h00, 1,'hA5,1,0, 2),   // R2 read
    mk(0,1,1,0,5,'h00, 1,'hA5,1,0, 6),   // R6 hold after CAS rise
    mk(0,0,1,0,6,'h00, 1,'h3C,4,0, 5),   // R5 page read
    mk(0,1,1,0,6,'h00, 1,'h3C,4,0, 6),
    mk(0,1,1,1,6,'h00, 0,'h00,4,0, 6),   // R6 OE high
    mk(0,1,1,0,6,'h00, 1,'h3C,4,0, 6),   // R6 OE low again
    mk(0,1,0,0,6,'h00, 0,'h00,4,0, 6),   // R6 WE pulse in page read
    mk(0,1,1,0,6,'h00, 0,'h00,4,0, 6),
    mk(0,0,1,0,5,'h00, 1,'hA5,4,0, 5),
    mk(0,0,0,0,5,'h77, 1,'hA5,3,0, 4),   // R4 read-modify-write
    mk(0,1,1,0,5,'h00, 1,'hA5,3,0, 4),
    mk(1,1,1,0,0,'h00, 0,'h00,3,0, 6),   // R6 both high
    mk(0,1,1,0,2,'h00, 0,'h00,3,0, 4),
    mk(0,0,1,0,5,'h00, 1,'h77,1,0, 4),   // R4 new data stored
    mk(0,1,1,0,5,'h00, 1,'h77,1,0, 6),
    mk(1,1,1,0,0,'h00, 0,'h00,1,0, 6),
    mk(0,1,1,0,4,'h00, 0,'h00,1,0, 7),   // R7 row-only
    mk(1,1,1,0,4,'h00, 0,'h00,6,0, 7),
    mk(0,1,1,0,2,'h00, 0,'h00,6,0, 9),   // R9 hidden refresh
    mk(0,0,1,0,6,'h00, 1,'h3C,1,0, 9),
    mk(1,0,1,0,6,'h00, 1,'h3C,1,0, 9),
    mk(0,0,1,0,3,'h00, 1,'h3C,8,0, 9),
    mk(1,0,1,0,3,'h00, 1,'h3C,8,0, 9),
    mk(1,1,1,0,0,'h00, 0,'h00,8,0, 9),
    mk(1,0,1,0,0,'h00, 0,'h00,8,0, 8),   // R8 counter refresh
    mk(0,0,1,0,7,'h00, 0,'h00,7,0, 8),
    mk(1,1,1,0,0,'h00, 0,'h00,7,0, 8),
    mk(1,0,0,0,0,'h00, 0,'h00,7,0,10),   // R10 test entry
    mk(0,0,0,0,0,'h00, 0,'h00,9,0,10),
    mk(1,1,1,0,0,'h00, 0,'h00,9,0,10),
    mk(0,0,0,0,5,'hFF, 0,'h00,9,1,11),   // R11 simultaneous fall
    mk(1,1,1,0,0,'h00, 0,'h00,9,0,11),
    mk(0,1,1,0,2,'h00, 0,'h00,9,0,11),
    mk(0,0,1,0,5,'h00, 1,'h77,1,0,11),   // R11 cell unchanged
    mk(1,1,1,0,0,'h00, 0,'h00,1,0,11),
    mk(1,0,1,0,0,'h00, 0,'h00,1,0,11),
    mk(0,0,1,0,0,'h00, 0,'h00,7,0, 8),
    mk(0,1,1,0,0,'h00, 0,'h00,7,0,11),
    mk(0,0,0,0,5,'h11, 0,'h00,7,1,11),   // R11 CAS fall in refresh
    mk(1,1,1,0,0,'h00, 0,'h00,7,0,11),
    mk(0,1,1,0,2,'h00, 0,'h00,7,0,11),
    mk(0,0,1,0,5,'h00, 1,'h77,1,0,11),   // R11 cell unchanged
    mk(1,1,1,0,0,'h00, 0,'h00,1,0,11)
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       dout_en, test_mode, seq_err;
  logic [3:0] cyc_kind;
  logic [2:0] rfsh_row;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edo_strobe_decoder #(.ADDR_W(3), .DATA_W(8)) u_dut (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .cyc_kind(cyc_kind),
    .rfsh_row(rfsh_row), .test_mode(test_mode), .seq_err(seq_err)
  );

  task automatic drive(input logic r, input logic c, input logic w, input logic o,
                       input logic [2:0] a, input logic [7:0] d);
    ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a; din = d;
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string rq;
      v = VEC[i];
      rq = $sformatf("R%0d", v.req);
      drive(v.ras, v.cas, v.we, v.oe, v.addr, v.din);
      check(dout_en == v.en, rq, $sformatf("step %0d dout_en", i), dout_en, v.en);
      check(dout == v.dout, rq, $sformatf("step %0d dout", i), dout, v.dout);
      check(cyc_kind == v.kind, rq, $sformatf("step %0d kind", i), cyc_kind, v.kind);
      check(seq_err == v.err, rq, $sformatf("step %0d seq_err", i), seq_err, v.err);
    end
    // R8 counter after hidden, plain and one more counter refresh
    check(rfsh_row == 3'd2, "R8", "rfsh_row after table", rfsh_row, 2);
    check(test_mode == 1'b0, "R10", "test_mode cleared by refresh", test_mode, 0);

    // R1 reset from a state with test mode set
    drive(1, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);
    drive(1, 1, 1, 0, 0, 0);
    check(test_mode == 1'b1, "R10", "test_mode set", test_mode, 1);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(dout_en == 1'b0, "R1", "reset dout_en", dout_en, 0);
    check(cyc_kind == 4'd0, "R1", "reset kind", cyc_kind, 0);
    check(seq_err == 1'b0, "R1", "reset seq_err", seq_err, 0);
    check(test_mode == 1'b0, "R1", "reset test_mode", test_mode, 0);
    check(rfsh_row == 3'd0, "R1", "reset rfsh_row", rfsh_row, 0);

    // R8 counter walk and wrap; address pins varied and ignored
    for (int i = 0; i < 9; i++) begin
      drive(1, 0, 1, 0, 3'(i ^ 5), 0);
      drive(0, 0, 1, 0, 3'(i ^ 5), 0);
      check(rfsh_row == 3'(i % 8), "R8", "counter row", rfsh_row, i % 8);
      check(cyc_kind == 4'd7, "R8", "counter kind", cyc_kind, 7);
      drive(1, 1, 1, 0, 0, 0);
    end

    // R7 row-only refresh reports latched row
    drive(0, 1, 1, 0, 3, 0);
    drive(1, 1, 1, 0, 0, 0);
    check(rfsh_row == 3'd3, "R7", "row-only row", rfsh_row, 3);
    check(cyc_kind == 4'd6, "R7", "row-only kind", cyc_kind, 6);
    check(dout_en == 1'b0, "R7", "row-only dout_en", dout_en, 0);

    // R10 test entry does not advance the counter; next refresh clears it
    drive(1, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);
    check(test_mode == 1'b1, "R10", "test_mode", test_mode, 1);
    check(cyc_kind == 4'd9, "R10", "test kind", cyc_kind, 9);
    drive(1, 1, 1, 0, 0, 0);
    drive(1, 0, 1, 0, 0, 0);
    drive(0, 0, 1, 0, 0, 0);
    check(rfsh_row == 3'd1, "R10", "counter held over test entry", rfsh_row, 1);
    check(test_mode == 1'b0, "R10", "test_mode cleared", test_mode, 0);
    drive(1, 1, 1, 0, 0, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule